// File: doc/BRIEF.md
# Timer Compare Channel with Waveform Output

This block is one compare channel of an 8-bit timer, together with the counter that feeds it. The counter advances only on cycles where the single-cycle `tick` enable is high. It can count up and wrap, clear itself on a compare hit, or run up and down between the two ends of its range. The channel holds a compare value written by software. When that value equals the running count on an enabled cycle, the channel sets an interrupt request flag. On the same hit it updates a waveform output bit according to a 2-bit action code.

In the two PWM modes a software write to the compare value goes into a shadow register. The shadow is copied into the live compare register only when the count sits at its top value on an enabled cycle, so a pulse never gets a torn width. In the non-PWM modes a write reaches the live register directly. A force strobe can apply the output action without a real hit. A software write to the counter masks compare hits until the timer next advances, so software can preload the counter with the compare value without causing a false event.

Top module: `tmr_cmp_channel`

## Requirements
- R1: While `rst_n` is low, the count, the live compare value, the shadow, the flag and the waveform output are all 0, and the counter direction is upward. After reset, `at_bottom` is 1 and `at_top` is 0.
- R2: In modes 0 (free run) and 1 (clear on hit), `cmp_wr` writes `cmp_wdata` into the live compare register. The new value is visible on `cmp_active` one clock later, whether or not `tick` is high.
- R3: In modes 2 (PWM up) and 3 (PWM up/down), `cmp_wr` writes only the shadow register. The shadow is copied to `cmp_active` on a clock where `tick` is high and `count` is 0xFF. If a write and a copy fall in the same clock, the old shadow is copied.
- R4: A hit happens on a clock where `tick` is 1, `cnt_wr` is 0, no counter-write mask is pending, and `count` equals `cmp_active`. After a hit, `cmp_flag` is 1 on the next clock.
- R5: On a hit, `out_mode` acts on `wave_out` for the next clock: 00 leaves it unchanged, 01 toggles it, 10 clears it, 11 sets it.
- R6: In modes 0 and 1, `force_cmp` applies the R5 action to `wave_out`, but it changes neither `cmp_flag` nor `count`. In modes 2 and 3, `force_cmp` has no effect.
- R7: `cnt_wr` loads `cnt_wdata` into `count` on the next clock, and it takes priority over `tick`. A mask is then set that blocks hits until a clock with `tick` high and `cnt_wr` low, and that clock is itself blocked. While `tick` stays low the mask persists. A `cnt_wr` clock also never produces a hit.
- R8: On each tick, `count` moves as follows. In modes 0 and 2 it adds 1 and wraps from 0xFF to 0x00. In mode 1, a hit loads 0 and any other tick adds 1. In mode 3 it counts up to 0xFF, then down to 0x00, then up again, so 0xFF is followed by 0xFE and 0x00 by 0x01.
- R9: `flag_clr` high clears `cmp_flag` on the next clock. If a hit occurs in the same clock, the flag is set instead.
- R10: `wave_out` keeps its value across any change of `mode`. It changes only on a hit or an accepted force.
- R11: `at_top` is 1 exactly when `count` is 0xFF, and `at_bottom` is 1 exactly when `count` is 0x00.
- R12: On clocks with `tick` low and `cnt_wr` low, `count` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer advance enable, one clock wide |
| mode | input | 2 | 0 free run, 1 clear on hit, 2 PWM up, 3 PWM up/down |
| out_mode | input | 2 | Hit action on the waveform: 00 hold, 01 toggle, 10 clear, 11 set |
| cmp_wr | input | 1 | Software write of the compare value |
| cmp_wdata | input | 8 | Compare value to write |
| cnt_wr | input | 1 | Software write of the counter |
| cnt_wdata | input | 8 | Counter value to write |
| force_cmp | input | 1 | Force strobe for the output action |
| flag_clr | input | 1 | Write-one-to-clear of the compare flag |
| count | output | 8 | Current count |
| cmp_active | output | 8 | Live compare value |
| cmp_flag | output | 1 | Compare interrupt request |
| wave_out | output | 1 | Waveform output bit |
| at_top | output | 1 | Count is at 0xFF |
| at_bottom | output | 1 | Count is at 0x00 |

## Verification
Every result of this block is due exactly one clock after the clock in which its cause was sampled: the count step, the compare-register write or shadow copy, the flag set or clear, and the waveform change. The one exception is the hit mask, which persists over any number of idle clocks until the next tick. The bench drives inputs on the falling edge and keeps a behavioural model that advances on each rising edge, and it compares every output at the following falling edge, one clock after the inputs. The directed checks count the ticks to each expected hit and sample one clock after the deciding tick, for example one clock after the copy tick at 0xFF and one clock after the blocked tick that follows a counter write.

// File: rtl/tmr_cmp_channel.sv
module tmr_cmp_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [1:0]   out_mode,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         force_cmp,
  input  logic         flag_clr,
  output logic [W-1:0] count,
  output logic [W-1:0] cmp_active,
  output logic         cmp_flag,
  output logic         wave_out,
  output logic         at_top,
  output logic         at_bottom
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = '0;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] shadow;
  logic [W-1:0] cnt_nx;
  logic         dir_dn, dir_nx;
  logic         blk;
  logic         wave_nx;

  wire pwm   = mode[1];
  wire hit   = tick && !blk && !cnt_wr && (count == cmp_active);
  wire act   = hit || (force_cmp && !pwm);
  wire copy  = pwm && tick && (count == TOP);

  assign at_top    = (count == TOP);
  assign at_bottom = (count == BOT);

  always_comb begin
    dir_nx = dir_dn;
    case (mode)
      2'd1:    cnt_nx = hit ? BOT : count + ONE;
      2'd3: begin
        if (dir_dn) begin
          if (count == BOT) begin cnt_nx = ONE; dir_nx = 1'b0; end
          else cnt_nx = count - ONE;
        end else begin
          if (count == TOP) begin cnt_nx = TOP - ONE; dir_nx = 1'b1; end
          else cnt_nx = count + ONE;
        end
      end
      default: cnt_nx = count + ONE;
    endcase
  end

  always_comb begin
    case (out_mode)
      2'b01:   wave_nx = ~wave_out;
      2'b10:   wave_nx = 1'b0;
      2'b11:   wave_nx = 1'b1;
      default: wave_nx = wave_out;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      dir_dn <= 1'b0;
      blk    <= 1'b0;
    end else if (cnt_wr) begin
      count  <= cnt_wdata;
      blk    <= 1'b1;
    end else if (tick) begin
      count  <= cnt_nx;
      dir_dn <= dir_nx;
      blk    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_active <= '0;
      shadow     <= '0;
    end else begin
      if (cmp_wr) shadow <= cmp_wdata;
      if (cmp_wr && !pwm) cmp_active <= cmp_wdata;
      else if (copy)      cmp_active <= shadow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_flag <= 1'b0;
      wave_out <= 1'b0;
    end else begin
      if (hit)           cmp_flag <= 1'b1;
      else if (flag_clr) cmp_flag <= 1'b0;
      if (act) wave_out <= wave_nx;
    end
  end

  a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr && !pwm |=> cmp_active == $past(cmp_wdata));

  a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pwm && !(tick && at_top) |=> $stable(cmp_active));

  a_r4_flag_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !blk && !cnt_wr && (count == cmp_active) |=> cmp_flag);

  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (blk || cnt_wr) && !(force_cmp && !pwm) && !flag_clr |=> $stable(cmp_flag) && $stable(wave_out));

  a_r6_force_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    force_cmp && !tick && !cnt_wr |=> $stable(count));

  a_r6_force_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    force_cmp && !tick && !flag_clr |=> $stable(cmp_flag));

  a_r8_reverse_top: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd3 && tick && !cnt_wr && !dir_dn && at_top |=> count == TOP - ONE);

  a_r10_wave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !force_cmp |=> $stable(wave_out));

  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_wr |=> $stable(count));
endmodule

// File: tb/tmr_cmp_channel_tb_top.sv
module tmr_cmp_channel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, cmp_wr = 0, cnt_wr = 0, force_cmp = 0, flag_clr = 0;
  logic [1:0] mode = 0, out_mode = 0;
  logic [7:0] cmp_wdata = 0, cnt_wdata = 0;
  logic [7:0] count, cmp_active;
  logic cmp_flag, wave_out, at_top, at_bottom;

  int tests = 0, fails = 0;
  bit done = 0;

  int m_cnt, m_ocr, m_buf;
  bit m_dn, m_blk, m_flag, m_wave;

  always #4 clk = ~clk;

  tmr_cmp_channel #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .out_mode(out_mode),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .force_cmp(force_cmp), .flag_clr(flag_clr), .count(count), .cmp_active(cmp_active),
    .cmp_flag(cmp_flag), .wave_out(wave_out), .at_top(at_top), .at_bottom(at_bottom)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ocr = 0; m_buf = 0; m_dn = 0; m_blk = 0; m_flag = 0; m_wave = 0;
    end else begin
      bit pw, match, doit;
      int n_cnt, n_ocr;
      bit n_dn;
      pw = (mode >= 2);
      match = tick && !m_blk && !cnt_wr && (m_cnt == m_ocr);
      doit = match || (force_cmp && !pw);
      n_cnt = m_cnt; n_dn = m_dn; n_ocr = m_ocr;
      if (cnt_wr) begin
        n_cnt = cnt_wdata;
        m_blk = 1;
      end else if (tick) begin
        m_blk = 0;
        if (mode == 1) n_cnt = match ? 0 : (m_cnt + 1) % 256;
        else if (mode == 3) begin
          if (m_dn) begin
            if (m_cnt == 0) begin n_cnt = 1; n_dn = 0; end else n_cnt = m_cnt - 1;
          end else begin
            if (m_cnt == 255) begin n_cnt = 254; n_dn = 1; end else n_cnt = m_cnt + 1;
          end
        end else n_cnt = (m_cnt + 1) % 256;
      end
      if (cmp_wr && !pw) n_ocr = cmp_wdata;
      else if (pw && tick && m_cnt == 255) n_ocr = m_buf;
      if (cmp_wr) m_buf = cmp_wdata;
      if (match) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (doit) begin
        if (out_mode == 1) m_wave = !m_wave;
        else if (out_mode == 2) m_wave = 0;
        else if (out_mode == 3) m_wave = 1;
      end
      m_cnt = n_cnt; m_dn = n_dn; m_ocr = n_ocr;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_cmp();
    chk(count, m_cnt, "R8 count vs model");
    chk(cmp_active, m_ocr, "R3 cmp_active vs model");
    chk(cmp_flag, m_flag, "R4 flag vs model");
    chk(wave_out, m_wave, "R5 wave vs model");
    chk(at_top, m_cnt == 255, "R11 at_top vs model");
    chk(at_bottom, m_cnt == 0, "R11 at_bottom vs model");
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) model_cmp();
    tick = 0; cmp_wr = 0; cnt_wr = 0; force_cmp = 0; flag_clr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(count, 0, "R1 reset count");
    chk(cmp_flag, 0, "R1 reset flag");
    chk(wave_out, 0, "R1 reset wave");
    rst_n = 1;
    cyc();
    chk(at_bottom, 1, "R1 at_bottom after reset");
    chk(at_top, 0, "R1 at_top after reset");

    mode = 0; out_mode = 2'b01;
    cmp_wr = 1; cmp_wdata = 5; cyc();
    chk(cmp_active, 5, "R2 direct write without tick");
    ticks(6);
    chk(count, 6, "R8 free run count");
    chk(cmp_flag, 1, "R4 flag after hit at 5");
    chk(wave_out, 1, "R5 toggle on hit");

    flag_clr = 1; cyc();
    chk(cmp_flag, 0, "R9 clear flag");

    cnt_wr = 1; cnt_wdata = 4; cyc();
    ticks(1);
    chk(count, 5, "R7 load then tick");
    tick = 1; flag_clr = 1; cyc();
    chk(cmp_flag, 1, "R9 set wins over clear");
    flag_clr = 1; cyc();

    cnt_wr = 1; cnt_wdata = 5; cyc();
    repeat (4) cyc();
    chk(count, 5, "R12 idle keeps count");
    ticks(1);
    chk(cmp_flag, 0, "R7 masked hit after counter write");
    chk(count, 6, "R7 count advances on masked tick");
    chk(wave_out, 0, "R7 wave unchanged by masked tick");

    out_mode = 2'b11; force_cmp = 1; cyc();
    chk(wave_out, 1, "R6 force sets wave");
    chk(cmp_flag, 0, "R6 force leaves flag");
    chk(count, 6, "R6 force leaves count");

    mode = 2; out_mode = 2'b10; force_cmp = 1; cyc();
    chk(wave_out, 1, "R6 force ignored in PWM");
    mode = 1; cyc(); mode = 3; cyc(); mode = 0; cyc();
    chk(wave_out, 1, "R10 wave kept across mode change");

    mode = 2; cmp_wr = 1; cmp_wdata = 8'h40; cyc();
    chk(cmp_active, 5, "R3 shadow write not live");
    cnt_wr = 1; cnt_wdata = 8'hFE; cyc();
    ticks(1);
    chk(at_top, 1, "R11 at_top at 0xFF");
    chk(cmp_active, 5, "R3 no copy before top tick");
    ticks(1);
    chk(cmp_active, 8'h40, "R3 copy at top");
    chk(count, 0, "R8 PWM up wrap");

    mode = 1; cmp_wr = 1; cmp_wdata = 3; cyc();
    cnt_wr = 1; cnt_wdata = 0; cyc();
    ticks(3);
    chk(count, 3, "R8 clear-on-hit counting");
    ticks(1);
    chk(count, 0, "R8 clear-on-hit reload");

    mode = 3; cnt_wr = 1; cnt_wdata = 8'hFE; cyc();
    ticks(2);
    chk(count, 8'hFE, "R8 up/down reversal at top");
    cnt_wr = 1; cnt_wdata = 1; cyc();
    ticks(2);
    chk(count, 1, "R8 up/down reversal at bottom");

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 49) == 0) out_mode = 2'($urandom_range(0, 3));
      tick      = ($urandom_range(0, 2) != 0);
      cmp_wr    = ($urandom_range(0, 29) == 0);
      cmp_wdata = 8'($urandom_range(0, 255));
      cnt_wr    = ($urandom_range(0, 39) == 0);
      cnt_wdata = 8'($urandom_range(0, 255));
      force_cmp = ($urandom_range(0, 19) == 0);
      flag_clr  = ($urandom_range(0, 9) == 0);
      cyc();
    end
    finish_run();
  end
endmodule